// File: doc/BRIEF.md
# Keyed watchdog timer

A memory-mapped watchdog counter for a chip's reset path. Software programs a timeout code and an expiry action, turns the counter on, and then writes a fixed reload pattern at regular intervals. If those reloads stop, the counter runs out and the block drives a system reset pulse.

The block has two protections against stray software. The configuration and mode registers accept a write only when the upper halfword of the write data holds an unlock key. The countdown restarts only when the exact reload pattern is written to the control location. Time is counted in ticks of a slow 2 Hz strobe, so one tick is half a second. The timeout codes map to intervals that are not evenly spaced, and the shortest interval is half a second.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the configuration and mode registers read zero, the watchdog is disabled and `sys_rst_o` is low.
- R2: A write to configuration (offset 0x14) or mode (offset 0x18) is stored only when wdata[31:16] equals 0x16AA. The lower 16 bits are stored. Any other write leaves the register unchanged. Reads return the stored value with bits [31:16] as zero.
- R3: A write to the control location (offset 0x10) reloads the countdown only when wdata[12:0] equals 0x14AF, that is bit 0 set and bits [12:1] equal 0xA57. Bits above 12 are not examined. Any other value leaves the count unchanged.
- R4: The timeout code is mode bits [7:4], and the reload value in ticks is set by that code. Code 0 gives 1 tick. Codes 1 to 6 give 2 to 12 ticks. Codes 7, 8, 9, 0xA and 0xB give 16, 20, 24, 28 and 32 ticks. Codes 0xC to 0xF give 32 ticks.
- R5: Mode bit 0 enables counting. While it is clear, ticks have no effect on the count.
- R6: The counter expires on a tick that arrives while the block is enabled and the count is 1 or less. If configuration bits [1:0] equal 01, `sys_rst_o` then goes high from the next cycle for exactly 16 cycles, and mode bit 0 is cleared.
- R7: If configuration bits [1:0] hold any value other than 01, an expiry produces no reset pulse and the block stays enabled.
- R8: A mode write changes the timeout code but does not reload the count. The new interval takes effect at the next valid reload.
- R9: If a valid reload and an expiring tick arrive in the same cycle, the reload wins. No reset occurs and the count restarts from the full interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rdata | output | 32 | Read data for `addr`, combinational |
| tick | input | 1 | One-cycle 2 Hz time-base strobe |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The key collision is between a software reload and the tick that would make the counter expire, when both occur on the same clock edge. The bench sets up a count of one tick. It then drives the reload write and the tick strobe in the same cycle. It checks that no reset pulse follows, and that a full two ticks are then needed before expiry. A second overlap, a mode write that arrives while a count is already running, is checked by confirming that the old count still expires on schedule.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 6;

    localparam logic [ADDR_W-1:0] OFS_KICK = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h18;

    localparam logic [HALF_W-1:0] UNLOCK_KEY = 16'h16AA;
    localparam int                KICK_W     = 13;
    localparam logic [KICK_W-1:0] KICK_WORD  = 13'h14AF;
    localparam logic [1:0]        ACT_SYSRST = 2'b01;

    // Low byte of the mode register
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [2:0]        spare;
        logic              en;
    } mode_lo_t;

    // Decoded bus write events
    typedef struct packed {
        logic              kick;
        logic              cfg_wr;
        logic              mode_wr;
        logic [HALF_W-1:0] data;
    } wr_evt_t;

    // Reload value in half-second ticks for a timeout code
    function automatic logic [CNT_W-1:0] code_to_ticks(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] c;
        c = CNT_W'(code);
        if (code == '0)
            return CNT_W'(1);
        else if (code <= 4'd6)
            return c << 1;
        else if (code <= 4'd11)
            return ((c - CNT_W'(7)) << 2) + CNT_W'(16);
        else
            return CNT_W'(32);
    endfunction

endpackage

// File: rtl/kwd_decode.sv
module kwd_decode
    import kwd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output wr_evt_t           evt
);
    logic key_ok;

    always_comb begin
        key_ok      = (wdata[DATA_W-1:HALF_W] == UNLOCK_KEY);
        evt.data    = wdata[HALF_W-1:0];
        evt.kick    = wr_en && (addr == OFS_KICK) && (wdata[KICK_W-1:0] == KICK_WORD);
        evt.cfg_wr  = wr_en && (addr == OFS_CFG)  && key_ok;
        evt.mode_wr = wr_en && (addr == OFS_MODE) && key_ok;
    end
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_evt_t           evt,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [HALF_W-1:0] cfg_q,
    output logic [HALF_W-1:0] mode_q,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (evt.cfg_wr) begin
            cfg_q <= evt.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else begin
            if (evt.mode_wr) begin
                mode_q <= evt.data;
            end
            // an expiry with reset action turns the block off
            if (clr_en) begin
                mode_q[0] <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (addr)
            OFS_CFG:  rdata = {{HALF_W{1'b0}}, cfg_q};
            OFS_MODE: rdata = {{HALF_W{1'b0}}, mode_q};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             kick,
    input  logic             tick,
    input  logic             en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    always_comb begin
        expire = en && tick && !kick && (cnt_q <= CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (kick) begin
            cnt_q <= load_val;
        end else if (en && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (fire && (left_q == '0)) begin
            left_q <= PW'(PULSE_LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - PW'(1);
        end
    end

    assign pulse = (left_q != '0);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import kwd_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick,
    output logic              sys_rst_o
);
    wr_evt_t           evt;
    logic [HALF_W-1:0] cfg_q;
    logic [HALF_W-1:0] mode_q;
    mode_lo_t          mode_lo;
    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  load_val;
    logic              expire;
    logic              fire;

    kwd_decode u_decode (
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .evt   (evt)
    );

    kwd_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .clr_en (fire),
        .addr   (addr),
        .cfg_q  (cfg_q),
        .mode_q (mode_q),
        .rdata  (rdata)
    );

    always_comb begin
        mode_lo  = mode_lo_t'(mode_q[7:0]);
        load_val = code_to_ticks(mode_lo.code);
        fire     = expire && (cfg_q[1:0] == ACT_SYSRST);
    end

    kwd_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .kick     (evt.kick),
        .tick     (tick),
        .en       (mode_lo.en),
        .load_val (load_val),
        .cnt_q    (cnt_w),
        .expire   (expire)
    );

    kwd_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .pulse (sys_rst_o)
    );
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
    import kwd_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_en,
    input logic              tick,
    input logic              sys_rst_o,
    input logic [CNT_W-1:0]  cnt,
    input logic [HALF_W-1:0] cfg,
    input logic [HALF_W-1:0] mode
);
    logic    kick_ok;
    logic    ctl_bad;
    logic    cfg_nokey;
    int unsigned hi_run;

    assign kick_ok   = wr_en && (addr == OFS_KICK) && (wdata[KICK_W-1:0] == KICK_WORD);
    assign ctl_bad   = wr_en && (addr == OFS_KICK) && (wdata[KICK_W-1:0] != KICK_WORD);
    assign cfg_nokey = wr_en && (addr == OFS_CFG) && (wdata[DATA_W-1:HALF_W] != UNLOCK_KEY);

    always_ff @(posedge clk) begin
        if (rst)            hi_run <= 0;
        else if (sys_rst_o) hi_run <= hi_run + 1;
        else                hi_run <= 0;
    end

    assert_pulse_len_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_o) |-> hi_run == PULSE_LEN);

    assert_pulse_max_R6: assert property (@(posedge clk) disable iff (rst)
        hi_run <= PULSE_LEN);

    assert_off_after_fire_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_o) |-> !mode[0]);

    assert_action_gate_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_o) |-> cfg[1:0] == 2'b01);

    assert_hold_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        (!mode[0] && !kick_ok) |=> $stable(cnt));

    assert_bad_kick_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl_bad && !tick) |=> $stable(cnt));

    assert_kick_loads_R3: assert property (@(posedge clk) disable iff (rst)
        kick_ok |=> cnt != '0);

    assert_key_gate_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_nokey |=> $stable(cfg));

    assert_kick_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (kick_ok && tick) |=> !$rose(sys_rst_o));
endmodule

bind keyed_wdog kwd_checker #(.PULSE_LEN(PULSE_LEN)) u_kwd_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wdata     (wdata),
    .wr_en     (wr_en),
    .tick      (tick),
    .sys_rst_o (sys_rst_o),
    .cnt       (cnt_w),
    .cfg       (cfg_q),
    .mode      (mode_q)
);

// File: tb/test_keyed_wdog.sv
module test_keyed_wdog;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 16;
    localparam logic [31:0] KEY  = 32'h16AA_0000;
    localparam logic [7:0]  A_KICK = 8'h10;
    localparam logic [7:0]  A_CFG  = 8'h14;
    localparam logic [7:0]  A_MODE = 8'h18;
    localparam logic [31:0] KICK = 32'h0000_14AF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic [31:0] rdata;
    logic        tick = 1'b0;
    logic        sys_rst_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_wdog i_keyed_wdog (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .wdata     (wdata),
        .wr_en     (wr_en),
        .rdata     (rdata),
        .tick      (tick),
        .sys_rst_o (sys_rst_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        #1 d = rdata;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic wait_quiet();
        for (int i = 0; i < 40 && sys_rst_o; i++) @(negedge clk);
    endtask

    task automatic arm(input logic [1:0] act, input logic [3:0] code);
        wr(A_CFG, KEY | 32'(act));
        wr(A_MODE, KEY | 32'({code, 4'b0001}));
        wr(A_KICK, KICK);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CFG, d);  chk("R1 cfg after reset", d, 0);
        rd(A_MODE, d); chk("R1 mode after reset", d, 0);
        chk("R1 reset out low", 32'(sys_rst_o), 0);
        do_tick(); do_tick();
        chk("R1 disabled, no expiry", 32'(sys_rst_o), 0);
    endtask

    task automatic t_key();
        logic [31:0] d;
        wr(A_CFG, 32'h0000_0001);
        rd(A_CFG, d);  chk("R2 keyless cfg ignored", d, 0);
        wr(A_CFG, 32'h16AB_0003);
        rd(A_CFG, d);  chk("R2 wrong key cfg ignored", d, 0);
        wr(A_CFG, KEY | 32'h0000_8003);
        rd(A_CFG, d);  chk("R2 keyed cfg stored, upper zero", d, 32'h0000_8003);
        wr(A_MODE, 32'h1234_00F0);
        rd(A_MODE, d); chk("R2 keyless mode ignored", d, 0);
        wr(A_CFG, KEY);
    endtask

    task automatic t_timeout(input logic [3:0] code, input int ticks);
        logic [31:0] d;
        int hi;
        arm(2'b01, code);
        for (int i = 0; i < ticks - 1; i++) do_tick();
        chk($sformatf("R4 code %0h no reset before tick %0d", code, ticks), 32'(sys_rst_o), 0);
        do_tick();
        chk($sformatf("R4 code %0h reset at tick %0d", code, ticks), 32'(sys_rst_o), 1);
        hi = 0;
        while (sys_rst_o && hi < 40) begin
            hi++;
            @(negedge clk);
        end
        chk("R6 pulse length", 32'(hi), 32'(PULSE));
        rd(A_MODE, d);
        chk("R6 enable cleared after expiry", d, 32'({code, 4'b0000}));
    endtask

    task automatic t_kick_pattern();
        arm(2'b01, 4'd1);
        do_tick();
        wr(A_KICK, 32'hFFFF_F4AF);
        do_tick();
        chk("R3 reload ignores bits above 12", 32'(sys_rst_o), 0);
        wr(A_KICK, 32'h0000_14AE);
        wr(A_KICK, 32'h0000_04AF);
        wr(A_CFG,  KEY | 32'h1);
        do_tick();
        chk("R3 bad patterns do not reload", 32'(sys_rst_o), 1);
        wait_quiet();
    endtask

    task automatic t_disable();
        logic [31:0] d;
        arm(2'b01, 4'd0);
        wr(A_MODE, KEY);
        for (int i = 0; i < 4; i++) do_tick();
        chk("R5 no expiry while disabled", 32'(sys_rst_o), 0);
        wr(A_MODE, KEY | 32'h1);
        do_tick();
        chk("R5 count held while disabled, expires after re-enable", 32'(sys_rst_o), 1);
        wait_quiet();
        rd(A_MODE, d);
        chk("R5 enable cleared after expiry", d, 0);
    endtask

    task automatic t_action();
        logic [31:0] d;
        arm(2'b10, 4'd0);
        do_tick();
        chk("R7 no reset with action 10", 32'(sys_rst_o), 0);
        do_tick();
        chk("R7 still no reset on next tick", 32'(sys_rst_o), 0);
        rd(A_MODE, d);
        chk("R7 block stays enabled", d, 32'h1);
        wr(A_MODE, KEY);
    endtask

    task automatic t_mode_noreload();
        arm(2'b01, 4'd1);
        do_tick();
        wr(A_MODE, KEY | 32'h0000_00B1);
        do_tick();
        chk("R8 mode write keeps running count", 32'(sys_rst_o), 1);
        wait_quiet();
    endtask

    task automatic t_keyless_mode();
        logic [31:0] d;
        arm(2'b01, 4'd1);
        wr(A_MODE, 32'h0000_0000);
        rd(A_MODE, d);
        chk("R2 keyless stop ignored", d, 32'h11);
        do_tick(); do_tick();
        chk("R2 keeps running after keyless stop", 32'(sys_rst_o), 1);
        wait_quiet();
    endtask

    task automatic t_collision();
        arm(2'b01, 4'd1);
        do_tick();
        @(negedge clk);
        addr = A_KICK; wdata = KICK; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0; wdata = '0;
        chk("R9 reload wins over expiring tick", 32'(sys_rst_o), 0);
        do_tick();
        chk("R9 full interval after collision, tick 1", 32'(sys_rst_o), 0);
        do_tick();
        chk("R9 expiry at tick 2 after collision", 32'(sys_rst_o), 1);
        wait_quiet();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_key();
        t_timeout(4'h0, 1);
        t_timeout(4'h3, 6);
        t_timeout(4'h7, 16);
        t_timeout(4'h9, 24);
        t_timeout(4'hB, 32);
        t_timeout(4'hD, 32);
        t_kick_pattern();
        t_disable();
        t_action();
        t_mode_noreload();
        t_keyless_mode();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule